// File: doc/BRIEF.md
# Page Bit-17 Swizzle Fixup Engine

This block repairs the contents of one memory page after the page has moved to a new physical location whose address bit 17 differs from the location the contents were written at. The engine keeps a small record table with one entry per page slot. Each entry holds a "recorded" flag and the bit-17 value captured when software last issued a save. A fixup command presents the page's current physical address. If the slot has a record and the recorded bit differs from the new bit 17, the engine walks the whole page 128 bytes at a time and swaps the lower and upper 64-byte halves of every block. It then reports the page as dirty.

Commands are presented on a single-cycle valid strobe and are taken only while the engine is idle. The walk goes through a word-wide memory port with a request/ready handshake. A 64-byte staging buffer holds the lower half of the current block while the upper half is copied down. Every command ends with a one-cycle completion pulse. A dirty pulse accompanies that completion pulse only when a swap took place.

Top module: `pgswap_engine`

## Requirements
- R1: A save command (cmd_op = 0) stores bit 17 of cmd_phys as the record for slot cmd_page and marks that slot recorded. A later fixup compares against exactly that stored value, whether it is 0 or 1.
- R2: A fixup command (cmd_op = 1) on a slot that has no record produces done without dirty and issues no memory transfer.
- R3: A fixup whose bit 17 equals the recorded bit produces done without dirty, issues no memory transfer and leaves memory unchanged.
- R4: A fixup whose bit 17 differs from the recorded bit exchanges bytes 0..63 with bytes 64..127 of every 128-byte block of the page. The page starts at cmd_phys with its low log2(PAGE_BYTES) bits cleared. With 64-bit words, word w of the page ends up holding the old word w XOR 8. The walk takes 4 transfers per word position per block, which is 1024 transfers for a 4096-byte page.
- R5: dirty is high only in the cycle where done is high, and only for a fixup that swapped the page.
- R6: busy rises the cycle after a swapping fixup is accepted and falls in the cycle done pulses. While busy is high, cmd_valid is ignored: no record changes and no extra done appears.
- R7: Once mem_req is raised, mem_addr, mem_we and mem_wdata hold steady until mem_ready is seen high. Every address lies inside the page being repaired.
- R8: A save, and a fixup that does not swap, pulse done in the cycle after acceptance without raising busy.
- R9: A fixup never modifies the record. Repeating a mismatching fixup swaps the page again, which restores the original contents.
- R10: Reset clears every record and drives busy, done, dirty and mem_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 1 | 0 = save record, 1 = fixup |
| cmd_page | input | IDX_W | Page slot index into the record table |
| cmd_phys | input | ADDR_W | Physical base address of the page |
| busy | output | 1 | Page walk in progress |
| done | output | 1 | One-cycle completion pulse per command |
| dirty | output | 1 | Page was swapped (qualifies done) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Transfer completes on this cycle |

## Verification
The bench attacks the three no-swap paths (no record, matching bit, commands arriving mid-walk). A design that ignored the recorded flag or compared against the wrong bit would start a walk there, and the bench would see an unexpected dirty pulse and memory traffic. Swapped pages are compared word by word after walks stalled at random by mem_ready. An engine that dropped a word on a stall, mixed up halves or stopped one block early would leave a visible hole in the page. Repeating a fixup, and saving a 1 before fixing up with a 0, catches an engine that rewrites or inverts its record.

// File: rtl/pgswap_pkg.sv
package pgswap_pkg;

    typedef enum logic {
        OP_SAVE  = 1'b0,
        OP_FIXUP = 1'b1
    } pgswap_op_e;

    typedef enum logic [2:0] {
        W_IDLE  = 3'd0,
        W_RD_LO = 3'd1,
        W_RD_HI = 3'd2,
        W_WR_LO = 3'd3,
        W_WR_HI = 3'd4
    } walk_state_e;

endpackage

// File: rtl/pgswap_record.sv
module pgswap_record #(
    parameter int NUM_PAGES = 64,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_bit
);
    typedef struct packed {
        logic [NUM_PAGES-1:0] valid;
        logic [NUM_PAGES-1:0] bits;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (wr_en) begin
            rec_d.valid[wr_idx] = 1'b1;
            rec_d.bits[wr_idx]  = wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign rd_valid = rec_q.valid[rd_idx];
    assign rd_bit   = rec_q.bits[rd_idx];

    assert_save_records_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rec_q.valid[$past(wr_idx)] && rec_q.bits[$past(wr_idx)] == $past(wr_bit)));

endmodule

// File: rtl/pgswap_walker.sv
module pgswap_walker
    import pgswap_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    output logic              busy,
    output logic              fin,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int BYTES_W    = DATA_W / 8;
    localparam int HALF_WORDS = 64 / BYTES_W;
    localparam int BLOCKS     = PAGE_BYTES / 128;
    localparam int HW_W       = (HALF_WORDS > 1) ? $clog2(HALF_WORDS) : 1;
    localparam int BLK_W      = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;

    typedef struct packed {
        walk_state_e                          state;
        logic [BLK_W-1:0]                     blk;
        logic [HW_W-1:0]                      wi;
        logic [HALF_WORDS-1:0][DATA_W-1:0]    buffer;
        logic [DATA_W-1:0]                    hold;
        logic [ADDR_W-1:0]                    base;
        logic                                 fin;
    } walk_t;

    walk_t w_d, w_q;
    logic  upper, last_w, last_b;

    always_comb begin
        w_d     = w_q;
        w_d.fin = 1'b0;
        upper   = (w_q.state == W_RD_HI) || (w_q.state == W_WR_HI);
        last_w  = (w_q.wi == HW_W'(HALF_WORDS - 1));
        last_b  = (w_q.blk == BLK_W'(BLOCKS - 1));

        mem_req   = (w_q.state != W_IDLE);
        mem_we    = (w_q.state == W_WR_LO) || (w_q.state == W_WR_HI);
        mem_wdata = (w_q.state == W_WR_LO) ? w_q.hold : w_q.buffer[w_q.wi];
        mem_addr  = w_q.base
                  + ADDR_W'(w_q.blk) * ADDR_W'(128)
                  + (upper ? ADDR_W'(64) : ADDR_W'(0))
                  + ADDR_W'(w_q.wi) * ADDR_W'(BYTES_W);

        case (w_q.state)
            W_IDLE: begin
                if (start) begin
                    w_d.base  = start_base;
                    w_d.blk   = '0;
                    w_d.wi    = '0;
                    w_d.state = W_RD_LO;
                end
            end
            W_RD_LO: begin
                if (mem_ready) begin
                    w_d.buffer[w_q.wi] = mem_rdata;
                    if (last_w) begin
                        w_d.wi    = '0;
                        w_d.state = W_RD_HI;
                    end else begin
                        w_d.wi = w_q.wi + HW_W'(1);
                    end
                end
            end
            W_RD_HI: begin
                if (mem_ready) begin
                    w_d.hold  = mem_rdata;
                    w_d.state = W_WR_LO;
                end
            end
            W_WR_LO: begin
                if (mem_ready) begin
                    if (last_w) begin
                        w_d.wi    = '0;
                        w_d.state = W_WR_HI;
                    end else begin
                        w_d.wi    = w_q.wi + HW_W'(1);
                        w_d.state = W_RD_HI;
                    end
                end
            end
            W_WR_HI: begin
                if (mem_ready) begin
                    if (last_w) begin
                        w_d.wi = '0;
                        if (last_b) begin
                            w_d.state = W_IDLE;
                            w_d.fin   = 1'b1;
                        end else begin
                            w_d.blk   = w_q.blk + BLK_W'(1);
                            w_d.state = W_RD_LO;
                        end
                    end else begin
                        w_d.wi = w_q.wi + HW_W'(1);
                    end
                end
            end
            default: w_d.state = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign busy = (w_q.state != W_IDLE);
    assign fin  = w_q.fin;

    assert_hold_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_addr_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - w_q.base) < ADDR_W'(PAGE_BYTES)));

endmodule

// File: rtl/pgswap_engine.sv
module pgswap_engine
    import pgswap_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 32,
    parameter int NUM_PAGES  = 64,
    parameter int SWZ_BIT    = 17,
    localparam int IDX_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [IDX_W-1:0]  cmd_page,
    input  logic [ADDR_W-1:0] cmd_phys,
    output logic              busy,
    output logic              done,
    output logic              dirty,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~(ADDR_W'(PAGE_BYTES) - ADDR_W'(1));

    typedef struct packed {
        logic walking;
        logic done;
        logic dirty;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic rec_we, rec_valid, rec_bit;
    logic walk_start, walk_busy, walk_fin;
    logic new_bit;

    pgswap_record #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_record (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rec_we),
        .wr_idx   (cmd_page),
        .wr_bit   (new_bit),
        .rd_idx   (cmd_page),
        .rd_valid (rec_valid),
        .rd_bit   (rec_bit)
    );

    pgswap_walker #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (walk_start),
        .start_base (cmd_phys & PAGE_MASK),
        .busy       (walk_busy),
        .fin        (walk_fin),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready)
    );

    assign new_bit = cmd_phys[SWZ_BIT];

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.dirty = 1'b0;
        rec_we      = 1'b0;
        walk_start  = 1'b0;
        if (ctl_q.walking) begin
            if (walk_fin) begin
                ctl_d.walking = 1'b0;
                ctl_d.done    = 1'b1;
                ctl_d.dirty   = 1'b1;
            end
        end else if (cmd_valid) begin
            if (cmd_op == OP_SAVE) begin
                rec_we     = 1'b1;
                ctl_d.done = 1'b1;
            end else if (rec_valid && (rec_bit != new_bit)) begin
                walk_start    = 1'b1;
                ctl_d.walking = 1'b1;
            end else begin
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy  = ctl_q.walking;
    assign done  = ctl_q.done;
    assign dirty = ctl_q.dirty;

    assert_dirty_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dirty |-> done);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_from_fixup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && cmd_op == OP_FIXUP));

    assert_traffic_only_walking_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && walk_busy));

endmodule

// File: tb/tb_pgswap_engine.sv
module tb_pgswap_engine;
    localparam int WORDS = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [5:0]  cmd_page = '0;
    logic [31:0] cmd_phys = '0;
    logic        busy, done, dirty, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;

    always #5 clk = ~clk;

    pgswap_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_page(cmd_page), .cmd_phys(cmd_phys), .busy(busy), .done(done),
        .dirty(dirty), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    typedef struct {
        bit    dirty;
        int    xfers;
        string tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] mem [WORDS];
    logic [63:0] expm[WORDS];
    logic [31:0] cur_base = 32'h0;
    logic [31:0] rel;
    int          xfer_cnt = 0;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;

    assign rel       = mem_addr - cur_base;
    assign mem_rdata = mem[rel[11:3]];

    // memory model write side and transfer counter
    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            xfer_cnt <= xfer_cnt + 1;
            if (mem_we) mem[rel[11:3]] <= mem_wdata;
        end
    end

    // ready generator plus handshake stability check (R7)
    always @(negedge clk) begin
        if (prev_stall) begin
            checks++;
            if (!(mem_req && mem_addr == prev_addr)) begin
                fails++;
                $display("FAIL R7 stalled request changed: req=%0b addr=%h expected req=1 addr=%h",
                         mem_req, mem_addr, prev_addr);
            end
        end
        if (mem_req && rel >= 32'd4096) begin
            checks++; fails++;
            $display("FAIL R7 address outside page: offset=%h expected below 1000", rel);
        end
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = mem_req && (lfsr[0] | lfsr[1]);
        prev_stall = mem_req && !mem_ready;
        prev_addr  = mem_addr;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R6 unexpected done: dirty=%0b expected no completion", dirty);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (dirty !== e.dirty || xfer_cnt != e.xfers) begin
                    fails++;
                    $display("FAIL %s: dirty=%0b xfers=%0d expected dirty=%0b xfers=%0d",
                             e.tag, dirty, xfer_cnt, e.dirty, e.xfers);
                end
            end
        end
        if (rst_n && dirty && !done) begin
            checks++; fails++;
            $display("FAIL R5 dirty without done: done=%0b expected 1", done);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R6 watchdog: cycles=%0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic issue(input bit op, input int page, input logic [31:0] phys,
                         input bit exp_dirty, input string tag, input bit poke);
        exp_t e;
        e.dirty = exp_dirty;
        e.xfers = exp_dirty ? 1024 : 0;
        e.tag   = tag;
        sb.push_back(e);
        @(negedge clk);
        if (op) cur_base = phys & 32'hFFFF_F000;
        xfer_cnt  = 0;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_page  = 6'(page);
        cmd_phys  = phys;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!exp_dirty) begin
            checks++;
            if (busy !== 1'b0) begin
                fails++;
                $display("FAIL R8 busy after non-walking command: busy=%0b expected 0", busy);
            end
        end else begin
            checks++;
            if (busy !== 1'b1) begin
                fails++;
                $display("FAIL R6 busy after swapping fixup: busy=%0b expected 1", busy);
            end
        end
        if (poke) begin
            repeat (5) @(negedge clk);
            cmd_valid = 1'b1;
            cmd_op    = 1'b0;
            cmd_page  = 6'd5;
            cmd_phys  = 32'h0002_0000;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic swap_expected();
        logic [63:0] old [WORDS];
        for (int w = 0; w < WORDS; w++) old[w] = expm[w];
        for (int w = 0; w < WORDS; w++) expm[w] = old[w ^ 8];
    endtask

    task automatic check_mem(input string tag);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int w = 0; w < WORDS; w++)
            if (mem[w] !== expm[w]) begin
                bad++;
                if (first < 0) first = w;
            end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: word %0d = %h expected %h (%0d words wrong)",
                     tag, first, mem[first], expm[first], bad);
        end
    endtask

    task automatic check_reset(input string tag);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || dirty !== 1'b0 || mem_req !== 1'b0) begin
            fails++;
            $display("FAIL %s: busy=%0b done=%0b dirty=%0b req=%0b expected 0 0 0 0",
                     tag, busy, done, dirty, mem_req);
        end
    endtask

    initial begin
        for (int w = 0; w < WORDS; w++) begin
            mem[w]  = {32'hC0DE_0000 | 32'(w), 32'(w * 7 + 3)};
            expm[w] = mem[w];
        end
        repeat (3) @(negedge clk);
        check_reset("R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        issue(1'b1, 3, 32'h0001_0000, 1'b0, "R2 fixup without record", 1'b0);
        issue(1'b0, 3, 32'h0001_0000, 1'b0, "R8 save completes", 1'b0);
        issue(1'b1, 3, 32'h0001_0000, 1'b0, "R3 matching bit no swap", 1'b0);
        check_mem("R3 memory untouched");

        issue(1'b1, 3, 32'h0003_4000, 1'b1, "R4 R5 mismatch swaps", 1'b1);
        swap_expected();
        check_mem("R4 halves exchanged");

        issue(1'b1, 3, 32'h0003_4000, 1'b1, "R9 record kept, swaps again", 1'b0);
        swap_expected();
        check_mem("R9 page restored");

        issue(1'b1, 5, 32'h0003_4000, 1'b0, "R6 command during walk ignored", 1'b0);

        issue(1'b0, 7, 32'h0003_4000, 1'b0, "R1 save bit one", 1'b0);
        issue(1'b1, 7, 32'h0001_0000, 1'b1, "R1 recorded one vs zero swaps", 1'b0);
        swap_expected();
        check_mem("R1 R4 swap at new base");
        issue(1'b1, 7, 32'h0003_4000, 1'b0, "R1 recorded one vs one no swap", 1'b0);

        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset("R10 reset mid-run");
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b1, 7, 32'h0001_0000, 1'b0, "R10 records cleared by reset", 1'b0);
        check_mem("R10 memory untouched after reset");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule